// File: doc/BRIEF.md
# Opcode-to-Functional-Unit Dispatcher

This block decides which execution unit receives an instruction. A fixed number of configured units each own a 256-bit capability map with one bit per opcode. A further background unit is always present after them and serves only the two trap opcodes, 0 and 255. When an issue request arrives, the dispatcher looks for units that support its opcode and are not busy. It takes the lowest-indexed one and returns its index one cycle later.

If units support the opcode but all of them are busy, the request is reported as stalled so that the issue stage can retry. If no unit supports the opcode, not even the background unit, the dispatcher raises an emulation trap. Capability maps are loaded one 32-bit word at a time through a plain write port, normally during configuration. A per-unit flag shows when a configured unit's map is still all zero, which is an invalid setup.

Top module: `unit_dispatch`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` into word `cfg_word` of unit `cfg_unit`. In word k, bit 31 stands for opcode 32k and bit 0 for opcode 32k+31. The write takes effect for requests issued in later cycles.
- R2: Reset clears every configured map to zero and drives `grant_valid`, `trap_emul` and `stall` low.
- R3: On a request, the granted unit is the lowest-indexed unit whose map has the opcode's bit set and whose `unit_busy` bit is low.
- R4: When no unit supports the opcode, the background unit included, `trap_emul` is raised and no grant is given.
- R5: A unit that supports the opcode but is busy is skipped. When every supporting unit is busy, `stall` is raised and `trap_emul` stays low.
- R6: The background unit has index NUM_UNITS and supports exactly opcodes 0 and 255. It loses to any lower-indexed unit that is free and supports the same opcode.
- R7: Results are registered, so they appear on the clock edge that follows the request. A request produces exactly one of grant, trap or stall. A cycle with no request produces none of them.
- R8: Two units may hold identical maps. The higher-indexed of the two is granted only when the lower one is busy.
- R9: `mask_empty[i]` is high exactly while configured unit i has an all-zero map.
- R10: A write whose `cfg_unit` is NUM_UNITS or above changes no map, so the background unit's opcode set stays fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Capability word write strobe |
| cfg_unit | input | IDX_W | Unit selected by the write |
| cfg_word | input | WSEL_W | Word index within the 256-bit map |
| cfg_data | input | WORD_W | Word value, MSB is the lowest opcode of the word |
| unit_busy | input | NUM_UNITS+1 | Busy flag per unit, background unit in the top bit |
| req_valid | input | 1 | Issue request present |
| req_opcode | input | 8 | Opcode of the request |
| grant_valid | output | 1 | A unit was granted for the previous cycle's request |
| grant_unit | output | IDX_W | Index of the granted unit |
| trap_emul | output | 1 | Previous request has no supporting unit |
| stall | output | 1 | Previous request is supported but every supporter was busy |
| mask_empty | output | NUM_UNITS | Per configured unit: map is all zero |

## Verification
Grant, trap and stall are due exactly one clock edge after the cycle in which a request is driven. The driver pushes one expected item for every cycle, idle cycles included. The monitor wakes a quarter period after each rising edge and compares the registered outputs with the oldest queued item, so any delay or early result shows up as a mismatch. `mask_empty` follows the map registers and is checked at the falling edge after a write. A write becomes visible to requests issued in the cycle after the write cycle, and the bench's reference model applies each write at that same point.

// File: rtl/opd_pkg.sv
package opd_pkg;
  localparam int OPC_W    = 8;
  localparam int CAP_BITS = 1 << OPC_W;

  // Map bit for an opcode: MSB is opcode 0, so the position is the complement.
  function automatic logic cap_has(input logic [CAP_BITS-1:0] cap,
                                   input logic [OPC_W-1:0] op);
    return cap[~op];
  endfunction

  // Opcodes served by the always-present background unit.
  function automatic logic bg_has(input logic [OPC_W-1:0] op);
    return (op == '0) || (op == '1);
  endfunction

  // Lowest bit index of word k inside the MSB-first map.
  function automatic int word_lsb(input int k, input int word_w);
    return CAP_BITS - word_w * (k + 1);
  endfunction
endpackage

// File: rtl/opd_mask_bank.sv
module opd_mask_bank
  import opd_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int WORD_W    = 32,
  parameter int IDX_W     = 3,
  parameter int WSEL_W    = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_unit,
  input  logic [WSEL_W-1:0]                  wr_word,
  input  logic [WORD_W-1:0]                  wr_data,
  output logic [NUM_UNITS-1:0][CAP_BITS-1:0] caps,
  output logic [NUM_UNITS-1:0]               empty
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n)
        caps[u] <= '0;
      else if (wr_en && wr_unit == IDX_W'(u))
        caps[u][word_lsb(int'(wr_word), WORD_W) +: WORD_W] <= wr_data;
    end
    assign empty[u] = (caps[u] == '0);
  end
endmodule

// File: rtl/opd_match.sv
module opd_match
  import opd_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic [NUM_UNITS-1:0][CAP_BITS-1:0] caps,
  input  logic [OPC_W-1:0]                   opcode,
  output logic [NUM_UNITS:0]                 hit
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_hit
    assign hit[u] = cap_has(caps[u], opcode);
  end
  assign hit[NUM_UNITS] = bg_has(opcode);
endmodule

// File: rtl/opd_prio.sv
module opd_prio #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/unit_dispatch.sv
module unit_dispatch
  import opd_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int WORD_W    = 32,
  localparam int TOTAL    = NUM_UNITS + 1,
  localparam int IDX_W    = $clog2(TOTAL),
  localparam int WSEL_W   = $clog2(CAP_BITS / WORD_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_unit,
  input  logic [WSEL_W-1:0]    cfg_word,
  input  logic [WORD_W-1:0]    cfg_data,
  input  logic [TOTAL-1:0]     unit_busy,
  input  logic                 req_valid,
  input  logic [OPC_W-1:0]     req_opcode,
  output logic                 grant_valid,
  output logic [IDX_W-1:0]     grant_unit,
  output logic                 trap_emul,
  output logic                 stall,
  output logic [NUM_UNITS-1:0] mask_empty
);
  logic [NUM_UNITS-1:0][CAP_BITS-1:0] caps;
  logic [TOTAL-1:0]                   hit_vec;
  logic [TOTAL-1:0]                   free_vec;
  logic                               free_found;
  logic [IDX_W-1:0]                   free_idx;
  logic                               any_hit;

  opd_mask_bank #(
    .NUM_UNITS(NUM_UNITS), .WORD_W(WORD_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_unit(cfg_unit),
    .wr_word(cfg_word), .wr_data(cfg_data), .caps(caps), .empty(mask_empty)
  );

  opd_match #(.NUM_UNITS(NUM_UNITS)) u_match (
    .caps(caps), .opcode(req_opcode), .hit(hit_vec)
  );

  assign free_vec = hit_vec & ~unit_busy;
  assign any_hit  = |hit_vec;

  opd_prio #(.N(TOTAL), .IDX_W(IDX_W)) u_prio (
    .cand(free_vec), .found(free_found), .idx(free_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_unit  <= '0;
      trap_emul   <= 1'b0;
      stall       <= 1'b0;
    end else begin
      grant_valid <= req_valid && free_found;
      grant_unit  <= (req_valid && free_found) ? free_idx : '0;
      trap_emul   <= req_valid && !any_hit;
      stall       <= req_valid && any_hit && !free_found;
    end
  end
endmodule

// File: rtl/opd_checker.sv
module opd_checker #(
  parameter int NUM_UNITS = 4,
  parameter int IDX_W     = 3,
  localparam int TOTAL    = NUM_UNITS + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [7:0]       req_opcode,
  input logic [TOTAL-1:0] unit_busy,
  input logic [TOTAL-1:0] hit_vec,
  input logic             grant_valid,
  input logic [IDX_W-1:0] grant_unit,
  input logic             trap_emul,
  input logic             stall
);
  logic             req_q;
  logic [7:0]       opc_q;
  logic [TOTAL-1:0] hit_q, busy_q, below;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0; opc_q <= '0; hit_q <= '0; busy_q <= '0;
    end else begin
      req_q <= req_valid; opc_q <= req_opcode; hit_q <= hit_vec; busy_q <= unit_busy;
    end
  end

  always_comb begin
    below = '0;
    for (int i = 0; i < TOTAL; i++) below[i] = (IDX_W'(i) < grant_unit);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |-> !(grant_valid || trap_emul || stall)); // R7
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $onehot({grant_valid, trap_emul, stall})); // R7
  AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> hit_q[grant_unit] && !busy_q[grant_unit]); // R3
  AST_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((hit_q & ~busy_q & below) == '0)); // R3
  AST_TRAP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_emul |-> hit_q == '0); // R4
  AST_STALL_ALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (hit_q != '0) && ((hit_q & ~busy_q) == '0)); // R5
  AST_BG_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && (opc_q == 8'h00 || opc_q == 8'hFF) |-> !trap_emul); // R6
endmodule

bind unit_dispatch opd_checker #(.NUM_UNITS(NUM_UNITS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
  .unit_busy(unit_busy), .hit_vec(hit_vec), .grant_valid(grant_valid),
  .grant_unit(grant_unit), .trap_emul(trap_emul), .stall(stall)
);

// File: tb/unit_dispatch_tb.sv
module unit_dispatch_tb;
  localparam int PERIOD = 10;
  localparam int N      = 4;
  localparam int TOTAL  = N + 1;
  localparam int IDX_W  = 3;

  typedef struct packed {
    logic             g;
    logic             t;
    logic             s;
    logic [IDX_W-1:0] u;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_unit = '0;
  logic [2:0]       cfg_word = '0;
  logic [31:0]      cfg_data = '0;
  logic [TOTAL-1:0] unit_busy = '0;
  logic             req_valid = 1'b0;
  logic [7:0]       req_opcode = '0;
  logic             grant_valid, trap_emul, stall;
  logic [IDX_W-1:0] grant_unit;
  logic [N-1:0]     mask_empty;

  int checks = 0;
  int errors = 0;
  item_t exp_q[$];
  logic [31:0] mdl [N][8];
  string tag_q[$];

  unit_dispatch #(.NUM_UNITS(N), .WORD_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
    .cfg_word(cfg_word), .cfg_data(cfg_data), .unit_busy(unit_busy),
    .req_valid(req_valid), .req_opcode(req_opcode), .grant_valid(grant_valid),
    .grant_unit(grant_unit), .trap_emul(trap_emul), .stall(stall),
    .mask_empty(mask_empty)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic item_t model(input logic [7:0] op, input logic [TOTAL-1:0] busy);
    item_t r = '0;
    logic [TOTAL-1:0] sup;
    for (int u = 0; u < N; u++) sup[u] = mdl[u][op / 32][31 - (op % 32)];
    sup[N] = (op == 8'd0) || (op == 8'd255);
    for (int u = TOTAL - 1; u >= 0; u--)
      if (sup[u] && !busy[u]) begin r.g = 1'b1; r.u = IDX_W'(u); end
    if (!r.g) begin
      if (sup != '0) r.s = 1'b1;
      else r.t = 1'b1;
    end
    return r;
  endfunction

  task automatic idle(input string tag);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0; unit_busy = '0;
    exp_q.push_back('0); tag_q.push_back(tag);
  endtask

  task automatic cfg(input int unit, input int word, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b1;
    cfg_unit = IDX_W'(unit); cfg_word = 3'(word); cfg_data = data;
    if (unit < N) mdl[unit][word] = data;   // R10: others change nothing
    exp_q.push_back('0); tag_q.push_back("R1 cfg cycle");
  endtask

  task automatic issue(input logic [7:0] op, input logic [TOTAL-1:0] busy, input string tag);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b1; req_opcode = op; unit_busy = busy;
    exp_q.push_back(model(op, busy)); tag_q.push_back(tag);
  endtask

  task automatic check_empty(input logic [N-1:0] e, input string tag);
    @(negedge clk);
    checks++;
    if (mask_empty !== e) begin
      errors++;
      $display("FAIL %s mask_empty actual=%b expected=%b", tag, mask_empty, e);
    end
  endtask

  // Monitor: compares each registered result with the item pushed one cycle earlier.
  initial begin
    item_t e, a;
    string t;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        a = '{g: grant_valid, t: trap_emul, s: stall, u: (grant_valid ? grant_unit : '0)};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual g=%b t=%b s=%b u=%0d expected g=%b t=%b s=%b u=%0d",
                   t, a.g, a.t, a.s, a.u, e.g, e.t, e.s, e.u);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int u = 0; u < N; u++) for (int w = 0; w < 8; w++) mdl[u][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state
    checks++;
    if (grant_valid !== 1'b0 || trap_emul !== 1'b0 || stall !== 1'b0) begin
      errors++;
      $display("FAIL R2 outputs after reset actual=%b%b%b expected=000", grant_valid, trap_emul, stall);
    end
    check_empty(4'hF, "R2/R9 empty maps after reset");

    issue(8'd0,   5'b00000, "R6 bg serves opcode 0");
    issue(8'd255, 5'b00000, "R6 bg serves opcode 255");
    issue(8'd7,   5'b00000, "R4 unsupported opcode traps");
    issue(8'd0,   5'b10000, "R5 bg busy stalls");
    idle("R7 idle after request");

    cfg(0, 3, 32'h0000_00FF);                 // opcodes 120..127
    check_empty(4'b1110, "R9 unit0 loaded");
    issue(8'd120, 5'b00000, "R1 first opcode of word");
    issue(8'd127, 5'b00000, "R1 last opcode of word");
    issue(8'd119, 5'b00000, "R1 neighbour below traps");
    issue(8'd128, 5'b00000, "R1 neighbour above traps");

    cfg(4, 0, 32'hFFFF_FFFF);
    cfg(7, 2, 32'hFFFF_FFFF);
    check_empty(4'b1110, "R10 out-of-range writes");
    issue(8'd5,  5'b00000, "R10 bg unchanged opcode 5");
    issue(8'd70, 5'b00000, "R10 bg unchanged opcode 70");

    for (int w = 0; w < 8; w++) cfg(1, w, 32'hFFFF_FFFF);
    for (int w = 0; w < 8; w++) cfg(2, w, 32'hFFFF_FFFF);
    check_empty(4'b1000, "R9 units 1 and 2 loaded");
    issue(8'd5,   5'b00000, "R3 general unit grant");
    issue(8'd120, 5'b00000, "R3 lowest index wins");
    issue(8'd120, 5'b00001, "R5 skip busy first");
    issue(8'd120, 5'b00011, "R8 identical map second copy");
    issue(8'd120, 5'b00111, "R5 all supporters busy");

    cfg(3, 0, 32'h8000_0000);
    cfg(3, 7, 32'h0000_0001);
    check_empty(4'b0000, "R9 all loaded");
    issue(8'd0,   5'b00000, "R6 lower unit beats bg");
    issue(8'd0,   5'b00110, "R3 unit3 opcode 0");
    issue(8'd255, 5'b01110, "R6 bg after others busy");
    issue(8'd255, 5'b11110, "R5 stall opcode 255");

    for (int op = 0; op < 256; op++)
      issue(8'(op), 5'(op % 32), "R3/R5 sweep");
    idle("R7 idle");
    idle("R7 idle");
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule